// File: doc/BRIEF.md
# Streaming Hex Record Parser

This block takes a stream of ASCII characters, one per accepted beat, holding records in the Intel HEX text format. It decodes them and emits the data bytes they carry, each with its full 32-bit address. Every record is checked for framing, digit legality, minimum size, checksum, record type and length before any of its bytes leave the block. Data records are buffered internally and released one byte per cycle only after the whole record has been validated. Extended linear address records set the upper address half. An end-of-file record stops the parser.

Any violation stops the parser with a sticky error flag and a 3-bit error code. After an error or end of file, no further input is accepted until reset. A loader would place this block between a character source, such as a UART receive path, and a memory-writing engine.

Top module: `hex_rec_parser`

## Requirements
- R1: After reset, `char_ready_o` is 1 and `data_valid_o`, `eof_o`, `err_o` and `err_code_o` are 0. The upper address half is 0.
- R2: Between records, characters at or below 0x20 are consumed and skipped, and a colon (0x3A) opens a record. Any other character stops the parser with code 1 on the cycle after it is accepted.
- R3: Inside a record, a digit must be '0'-'9' or 'A'-'F' (uppercase only). A character above 0x20 that is not such a digit, or a character at or below 0x20 after an odd number of digits, gives code 2 on the cycle after it is accepted.
- R4: A character at or below 0x20 after an even number of digits ends the record. The decoded bytes are, in order: byte count, offset high, offset low, record type, payload, and a final checksum. The record is judged in the next cycle, in this priority: fewer than 5 bytes gives code 3; a nonzero 8-bit sum of all bytes (checksum included) gives code 4; a type other than 0, 1 or 4 gives code 5; a length error gives code 6.
- R5: A valid type-0 record emits its payload bytes in order, one per cycle, with `data_valid_o` high. The first byte appears two cycles after the terminator is accepted. Byte i carries `addr_o` = {upper half, offset} + i, computed in full 32 bits. `char_ready_o` is 0 while bytes are emitted. A count of zero emits nothing.
- R6: A type-0 record whose total length is not the count field plus 5 gives code 6.
- R7: A type-4 record must have exactly 7 bytes, otherwise code 6. When valid, it loads the upper address half from payload bytes 0 (high) and 1 (low), and that value holds for later records until reset.
- R8: A valid type-1 record raises `eof_o` and holds it. After that, `char_ready_o` stays 0 and no data is emitted until reset.
- R9: A record that fails any check emits no byte.
- R10: After an error, `err_o` stays 1, `err_code_o` holds its value, `char_ready_o` is 0 and no data is emitted until reset.
- R11: A record longer than MAX_DATA + 5 bytes gives code 6 on the cycle after its first excess byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_i | input | 8 | ASCII character |
| char_valid_i | input | 1 | Character present |
| char_ready_o | output | 1 | Character accepted when high together with valid |
| data_o | output | 8 | Decoded data byte |
| addr_o | output | 32 | Address of the decoded byte |
| data_valid_o | output | 1 | Data byte and address valid |
| eof_o | output | 1 | End-of-file record seen (sticky) |
| err_o | output | 1 | Parse error (sticky) |
| err_code_o | output | 3 | 1 frame, 2 digit, 3 short, 4 checksum, 5 type, 6 length |

## Verification
Character-level faults (framing, bad digit, overlength) are due one cycle after the offending character is accepted. Record-level faults and the first emitted byte are due one cycle later still, because the whole record is judged in a separate cycle. The bench drives each character at a falling edge and returns on the falling edge right after the accepting rising edge. It then samples the flags at exactly that edge and at the next one, and checks that an error or byte is absent at the first and present at the second. Emitted bytes are captured at falling edges and compared in order, with their addresses, once the record has drained.

// File: rtl/hexp_pkg.sv
package hexp_pkg;
  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_FRAME = 3'd1, E_DIGIT = 3'd2, E_SHORT = 3'd3,
    E_SUM = 3'd4, E_TYPE = 3'd5, E_LEN = 3'd6
  } err_e;

  typedef enum logic [2:0] {
    S_HUNT, S_HI, S_LO, S_EVAL, S_EMIT, S_EOF, S_ERR
  } state_e;

  localparam logic [7:0] T_DATA = 8'd0;
  localparam logic [7:0] T_EOF  = 8'd1;
  localparam logic [7:0] T_EXT  = 8'd4;
endpackage

// File: rtl/hexp_char_class.sv
module hexp_char_class (
  input  logic [7:0] ch_i,
  output logic       is_hex_o,
  output logic       is_term_o,
  output logic       is_colon_o,
  output logic [3:0] nib_o
);
  logic is_dec, is_upper;

  assign is_dec     = (ch_i >= 8'h30) && (ch_i <= 8'h39);
  assign is_upper   = (ch_i >= 8'h41) && (ch_i <= 8'h46);
  assign is_hex_o   = is_dec || is_upper;
  assign is_term_o  = (ch_i <= 8'h20);
  assign is_colon_o = (ch_i == 8'h3A);

  always_comb begin
    if (is_dec)        nib_o = ch_i[3:0];
    else if (is_upper) nib_o = ch_i[3:0] + 4'd9;
    else               nib_o = 4'd0;
  end
endmodule

// File: rtl/hexp_payload_buf.sv
module hexp_payload_buf #(
  parameter int DEPTH = 17
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [7:0]               wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [7:0]               rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/hex_rec_parser.sv
module hex_rec_parser
  import hexp_pkg::*;
#(
  parameter int MAX_DATA = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  char_i,
  input  logic        char_valid_i,
  output logic        char_ready_o,
  output logic [7:0]  data_o,
  output logic [31:0] addr_o,
  output logic        data_valid_o,
  output logic        eof_o,
  output logic        err_o,
  output logic [2:0]  err_code_o
);
  localparam int DEPTH   = MAX_DATA + 1;      // payload plus checksum
  localparam int AW      = $clog2(DEPTH);
  localparam int MAX_LEN = MAX_DATA + 5;
  localparam int CW      = $clog2(MAX_LEN + 1);

  state_e         state_q;
  err_e           code_q;
  logic [3:0]     nib_q;
  logic [CW-1:0]  cnt_q;
  logic [7:0]     sum_q, cnt_fld_q, type_q, b4_q, b5_q;
  logic [15:0]    off_q, upper_q;
  logic [AW-1:0]  idx_q;

  logic       is_hex, is_term, is_colon, accept, buf_we;
  logic [3:0] nib;
  logic [7:0] byte_now, rd_data;
  logic [8:0] cnt9;

  hexp_char_class i_class (
    .ch_i(char_i), .is_hex_o(is_hex), .is_term_o(is_term),
    .is_colon_o(is_colon), .nib_o(nib)
  );

  assign char_ready_o = (state_q == S_HUNT) || (state_q == S_HI) || (state_q == S_LO);
  assign accept       = char_valid_i && char_ready_o;
  assign byte_now     = {nib_q, nib};
  assign cnt9         = 9'(cnt_q);
  assign buf_we       = accept && (state_q == S_LO) && is_hex &&
                        (cnt_q >= CW'(4)) && (cnt_q < CW'(MAX_LEN));

  hexp_payload_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i(clk_i), .we_i(buf_we), .waddr_i(AW'(cnt_q - CW'(4))),
    .wdata_i(byte_now), .raddr_i(idx_q), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_HUNT;
      code_q    <= E_NONE;
      nib_q     <= '0;
      cnt_q     <= '0;
      sum_q     <= '0;
      cnt_fld_q <= '0;
      type_q    <= '0;
      b4_q      <= '0;
      b5_q      <= '0;
      off_q     <= '0;
      upper_q   <= '0;
      idx_q     <= '0;
    end else begin
      case (state_q)
        S_HUNT: if (accept) begin
          if (is_colon) begin
            state_q <= S_HI;
            cnt_q   <= '0;
            sum_q   <= '0;
          end else if (!is_term) begin
            state_q <= S_ERR;
            code_q  <= E_FRAME;
          end
        end
        S_HI: if (accept) begin
          if (is_hex) begin
            nib_q   <= nib;
            state_q <= S_LO;
          end else if (is_term) begin
            state_q <= S_EVAL;
          end else begin
            state_q <= S_ERR;
            code_q  <= E_DIGIT;
          end
        end
        S_LO: if (accept) begin
          if (!is_hex) begin
            state_q <= S_ERR;
            code_q  <= E_DIGIT;
          end else if (cnt_q == CW'(MAX_LEN)) begin
            state_q <= S_ERR;
            code_q  <= E_LEN;
          end else begin
            sum_q   <= sum_q + byte_now;
            cnt_q   <= cnt_q + CW'(1);
            state_q <= S_HI;
            if (cnt_q == CW'(0)) cnt_fld_q   <= byte_now;
            if (cnt_q == CW'(1)) off_q[15:8] <= byte_now;
            if (cnt_q == CW'(2)) off_q[7:0]  <= byte_now;
            if (cnt_q == CW'(3)) type_q      <= byte_now;
            if (cnt_q == CW'(4)) b4_q        <= byte_now;
            if (cnt_q == CW'(5)) b5_q        <= byte_now;
          end
        end
        S_EVAL: begin
          if (cnt_q < CW'(5)) begin
            state_q <= S_ERR;
            code_q  <= E_SHORT;
          end else if (sum_q != 8'd0) begin
            state_q <= S_ERR;
            code_q  <= E_SUM;
          end else if (type_q == T_EOF) begin
            state_q <= S_EOF;
          end else if (type_q == T_EXT) begin
            if (cnt9 != 9'd7) begin
              state_q <= S_ERR;
              code_q  <= E_LEN;
            end else begin
              upper_q <= {b4_q, b5_q};
              state_q <= S_HUNT;
            end
          end else if (type_q == T_DATA) begin
            if (cnt9 != {1'b0, cnt_fld_q} + 9'd5) begin
              state_q <= S_ERR;
              code_q  <= E_LEN;
            end else if (cnt_fld_q == 8'd0) begin
              state_q <= S_HUNT;
            end else begin
              idx_q   <= '0;
              state_q <= S_EMIT;
            end
          end else begin
            state_q <= S_ERR;
            code_q  <= E_TYPE;
          end
        end
        S_EMIT: begin
          if (9'(idx_q) + 9'd1 == {1'b0, cnt_fld_q}) state_q <= S_HUNT;
          idx_q <= idx_q + AW'(1);
        end
        default: ;
      endcase
    end
  end

  assign data_valid_o = (state_q == S_EMIT);
  assign data_o       = data_valid_o ? rd_data : 8'd0;
  assign addr_o       = {upper_q, off_q} + 32'(idx_q);
  assign eof_o        = (state_q == S_EOF);
  assign err_o        = (state_q == S_ERR);
  assign err_code_o   = code_q;
endmodule

// File: rtl/hexp_parser_chk.sv
module hexp_parser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        char_ready_o,
  input logic [31:0] addr_o,
  input logic        data_valid_o,
  input logic        eof_o,
  input logic        err_o,
  input logic [2:0]  err_code_o
);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_code_o));

  a_r10_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !char_ready_o && !data_valid_o && (err_code_o != 3'd0));

  a_r8_eof_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> eof_o && !char_ready_o && !data_valid_o);

  a_r5_no_accept_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !char_ready_o);

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o && $past(data_valid_o) |-> addr_o == $past(addr_o) + 32'd1);

  a_r8_eof_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && err_o));
endmodule

bind hex_rec_parser hexp_parser_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_ready_o(char_ready_o),
  .addr_o(addr_o), .data_valid_o(data_valid_o), .eof_o(eof_o),
  .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/test_hex_rec_parser.sv
module test_hex_rec_parser;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ch = 8'h00;
  logic ch_valid = 1'b0;
  logic ready, dv, eof, err;
  logic [7:0] dout;
  logic [31:0] addr;
  logic [2:0] code;

  int n_chk = 0, n_fail = 0, cap_n = 0;
  logic [7:0]  cap_d [64];
  logic [31:0] cap_a [64];
  logic [7:0]  pl [32];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hex_rec_parser i_hex_rec_parser (
    .clk_i(clk), .rst_ni(rst_n), .char_i(ch), .char_valid_i(ch_valid),
    .char_ready_o(ready), .data_o(dout), .addr_o(addr), .data_valid_o(dv),
    .eof_o(eof), .err_o(err), .err_code_o(code)
  );

  always @(negedge clk) if (rst_n && dv && cap_n < 64) begin
    cap_d[cap_n] = dout;
    cap_a[cap_n] = addr;
    cap_n++;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ch_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; cap_n = 0;
  endtask

  // returns on the falling edge right after the accepting rising edge
  task automatic put(input logic [7:0] c);
    @(negedge clk);
    while (!ready && !err && !eof) @(negedge clk);
    if (err || eof) return;
    ch = c; ch_valid = 1;
    @(negedge clk);
    ch_valid = 0;
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    put(hx(b[7:4])); put(hx(b[3:0]));
  endtask

  task automatic send_body(input logic [7:0] cnt, input logic [15:0] off, input logic [7:0] typ,
                           input int n, input bit corrupt);
    logic [7:0] s;
    s = cnt + off[15:8] + off[7:0] + typ;
    put(8'h3A);
    put_byte(cnt); put_byte(off[15:8]); put_byte(off[7:0]); put_byte(typ);
    for (int i = 0; i < n; i++) begin put_byte(pl[i]); s = s + pl[i]; end
    put_byte((8'd0 - s) ^ (corrupt ? 8'h01 : 8'h00));
  endtask

  task automatic send_rec(input logic [7:0] cnt, input logic [15:0] off, input logic [7:0] typ,
                          input int n, input bit corrupt);
    send_body(cnt, off, typ, n, corrupt);
    put(8'h0D); put(8'h0A);
    repeat (40) @(negedge clk);
  endtask

  // record-level failure: no error at the terminator edge, error one cycle later
  task automatic rec_fail(input string req, input logic [2:0] exp_code);
    put(8'h0D);
    check(req, "err before judge", err, 0);
    @(negedge clk);
    check(req, "err", err, 1);
    check(req, "code", code, exp_code);
    repeat (30) @(negedge clk);
    check("R9", "bytes from failed record", cap_n, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "ready", ready, 1);
    check("R1", "flags", {dv, eof, err, code}, 0);
  endtask

  task automatic t_data();
    do_reset();
    pl[0] = 8'hA5; pl[1] = 8'h00; pl[2] = 8'hFF; pl[3] = 8'h3C;
    put(8'h20); put(8'h0A);  // R2 skipped whitespace
    check("R2", "err after blanks", err, 0);
    send_body(8'd4, 16'h1234, 8'd0, 4, 0);
    put(8'h0D);
    check("R5", "dv at judge cycle", dv, 0);
    @(negedge clk);
    check("R5", "dv first", dv, 1);
    check("R5", "ready while emit", ready, 0);
    repeat (10) @(negedge clk);
    check("R5", "count", cap_n, 4);
    for (int i = 0; i < 4; i++) begin
      check("R5", "byte", cap_d[i], pl[i]);
      check("R5", "addr", cap_a[i], 32'h1234 + i);
    end
    check("R1", "ready after", ready, 1);
  endtask

  task automatic t_zero_len();
    do_reset();
    send_rec(8'd0, 16'h0100, 8'd0, 0, 0);
    check("R5", "zero count emits none", cap_n, 0);
    check("R5", "zero count no err", err, 0);
  endtask

  task automatic t_ext();
    do_reset();
    pl[0] = 8'h00; pl[1] = 8'h01;
    send_rec(8'd2, 16'h0000, 8'd4, 2, 0);
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    send_rec(8'd3, 16'hFFFE, 8'd0, 3, 0);
    check("R7", "count", cap_n, 3);
    check("R7", "addr0", cap_a[0], 32'h0001FFFE);
    check("R7", "addr1", cap_a[1], 32'h0001FFFF);
    check("R5", "addr carry", cap_a[2], 32'h00020000);
    do_reset();
    pl[0] = 8'h77;
    send_rec(8'd1, 16'h0010, 8'd0, 1, 0);
    check("R1", "upper cleared", cap_a[0], 32'h10);
  endtask

  task automatic t_eof();
    do_reset();
    send_body(8'd0, 16'h0000, 8'd1, 0, 0);
    put(8'h0D);
    @(negedge clk);
    check("R8", "eof", eof, 1);
    check("R8", "ready", ready, 0);
    ch = 8'h3A; ch_valid = 1;
    repeat (5) @(negedge clk);
    ch_valid = 0;
    check("R8", "still eof, no data", {eof, ready, 6'(cap_n)}, {1'b1, 1'b0, 6'd0});
  endtask

  task automatic t_bad_digit();
    do_reset();
    put(8'h3A); put(8'h31); put(8'h61);  // lowercase 'a'
    check("R3", "err", err, 1);
    check("R3", "code", code, 3'd2);
    ch = 8'h3A; ch_valid = 1;
    repeat (5) begin @(negedge clk); check("R10", "ready", ready, 0); end
    ch_valid = 0;
    check("R10", "code held", {err, code}, {1'b1, 3'd2});
  endtask

  task automatic t_odd();
    do_reset();
    put(8'h3A); put(8'h30); put(8'h0D);
    check("R3", "odd digits code", code, 3'd2);
  endtask

  task automatic t_frame();
    do_reset();
    put(8'h58);
    check("R2", "no colon err", err, 1);
    check("R2", "no colon code", code, 3'd1);
  endtask

  task automatic t_short();
    do_reset();
    put(8'h3A); put_byte(8'h00); put_byte(8'h00); put_byte(8'h00);
    rec_fail("R4", 3'd3);
  endtask

  task automatic t_sum();
    do_reset();
    pl[0] = 8'h12; pl[1] = 8'h34;
    send_body(8'd2, 16'h0040, 8'd0, 2, 1);
    rec_fail("R4", 3'd4);
  endtask

  task automatic t_type();
    do_reset();
    pl[0] = 8'h12;
    send_body(8'd1, 16'h0000, 8'd2, 1, 0);
    rec_fail("R4", 3'd5);
  endtask

  task automatic t_len();
    do_reset();
    pl[0] = 8'h12; pl[1] = 8'h34;
    send_body(8'd3, 16'h0000, 8'd0, 2, 0);
    rec_fail("R6", 3'd6);
    do_reset();
    pl[0] = 8'h12;
    send_body(8'd1, 16'h0000, 8'd4, 1, 0);
    rec_fail("R7", 3'd6);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 20; i++) pl[i] = 8'(i);
    put(8'h3A); put_byte(8'd20); put_byte(8'h00); put_byte(8'h00); put_byte(8'h00);
    for (int i = 0; i < 16; i++) put_byte(pl[i]);
    put_byte(8'h55);  // byte 21 still fits (payload index 16)
    check("R11", "no err at limit", err, 0);
    put(8'h35); put(8'h35);  // byte 22 exceeds
    check("R11", "err", err, 1);
    check("R11", "code", code, 3'd6);
    check("R9", "no output", cap_n, 0);
  endtask

  initial begin
    t_reset();
    t_data();
    t_zero_len();
    t_ext();
    t_eof();
    t_bad_digit();
    t_odd();
    t_frame();
    t_short();
    t_sum();
    t_type();
    t_len();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule